// File: doc/BRIEF.md
# LIN Frame Integrity Engine

This block protects and verifies a single LIN frame at byte level. It works in both the commanding and the responding role. It adds the two parity bits to a 6-bit frame identifier. It also runs the response checksum over a byte stream and works out how many response bytes the frame should carry. In the commanding role it hands out the protected identifier and the checksum byte to append. In the responding role it checks the received identifier parity, the received checksum and the byte count, and it raises sticky error flags.

A start-of-frame pulse latches the role, the check controls, the length source and the identifier byte. From the next cycle, bytes arrive with a valid strobe and a last-byte strobe. One cycle after the last byte is accepted, a done pulse appears together with the checksum and the error flags. Bit timing, break and sync fields, wakeup signalling and memory transfers are handled elsewhere.

Top module: `lin_frame_guard`

## Requirements
- R1: In the commanding role (`master_i`=1) with parity enabled, `pid_o` equals `{p1,p0,id[5:0]}` from the cycle after start of frame. Here `p0 = id0^id1^id2^id4` and `p1 = ~(id1^id3^id4^id5)`. For example, id 0x00 gives 0x80 and id 0x3F gives 0xBF.
- R2: With `par_off_i`=1, `pid_o` is the latched `frame_id_i` byte unchanged and `par_err_o` stays 0. In the responding role, `pid_o` is always the latched received byte.
- R3: In the responding role with parity enabled, `par_err_o` is 1 from the cycle after start of frame when bits 7:6 of `frame_id_i` differ from the parity computed over its bits 5:0.
- R4: With `len_from_id_i`=0, `exp_len_o` equals `len_cfg_i`+1, so it spans 1 to 256.
- R5: With `len_from_id_i`=1, `exp_len_o` follows identifier bits 5:4: codes 00 and 01 give 2, code 10 gives 4 and code 11 gives 8.
- R6: In the commanding role with the checksum enabled, `chk_o` is the bit inverse of the 8-bit sum of the data bytes. The sum adds any carry out of bit 7 back in. With `sum_classic_i`=1 only the data bytes are summed. With `sum_classic_i`=0 the protected identifier is added first.
- R7: In the responding role with the checksum enabled, the byte flagged last is the received checksum. `sum_err_o` is set when the data sum plus that byte, using the same carry rule, is not 0xFF.
- R8: With `sum_off_i`=1, `chk_o` is 0, `sum_err_o` stays 0, and the last byte counts as a data byte.
- R9: `cnt_err_o` is set when the number of data bytes up to and including the last strobe differs from `exp_len_o`.
- R10: `par_err_o`, `sum_err_o` and `cnt_err_o` hold their value until the next start of frame. That pulse clears the running sum, the byte count, `sum_err_o` and `cnt_err_o`.
- R11: `done_o` pulses for exactly one cycle, one cycle after the last byte is accepted. Bytes that arrive outside an open frame, or in the start-of-frame cycle, are ignored and leave `done_o` and `chk_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse; latches configuration and identifier |
| master_i | input | 1 | 1 = commanding role, 0 = responding role |
| par_off_i | input | 1 | Disable identifier parity |
| sum_off_i | input | 1 | Disable checksum |
| sum_classic_i | input | 1 | 1 = classic (data only), 0 = enhanced checksum |
| len_from_id_i | input | 1 | 1 = length from identifier bits 5:4 |
| len_cfg_i | input | LEN_W | Programmed length minus one |
| frame_id_i | input | 8 | Identifier (bits 5:0) or received protected identifier |
| byte_i | input | 8 | Response byte |
| byte_vld_i | input | 1 | Response byte valid |
| byte_last_i | input | 1 | Marks the final byte of the response |
| pid_o | output | 8 | Protected or received identifier |
| exp_len_o | output | LEN_W+1 | Expected number of data bytes |
| done_o | output | 1 | One-cycle pulse after the last byte |
| chk_o | output | 8 | Checksum byte to append |
| par_err_o | output | 1 | Identifier parity error |
| sum_err_o | output | 1 | Checksum error |
| cnt_err_o | output | 1 | Data count error |

## Verification
The assertions check several properties on every cycle:
- the error flags never drop without a start-of-frame pulse;
- `done_o` never lasts two cycles;
- no parity or checksum error appears in the commanding role;
- no parity error appears while parity is off;
- the expected length stays within 1 to 256;
- the byte counter never wraps.

Only the bench scenarios can show that the parity bits, the checksum values under each coverage, the length decoding and the count mismatch are correct. The same holds for the handling of bytes that are dropped outside a frame. The bench checks these against its own model over random and boundary frames, including a 256-byte response.

// File: rtl/lin_guard_pkg.sv
package lin_guard_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 6;

  typedef struct packed {
    logic master;
    logic par_off;
    logic sum_off;
    logic sum_classic;
    logic len_from_id;
  } cfg_t;

  // 8-bit add, carry out of bit 7 folded back in
  function automatic logic [BYTE_W-1:0] add_eac(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
  endfunction
endpackage

// File: rtl/lin_pid_unit.sv
module lin_pid_unit
  import lin_guard_pkg::*;
(
  input  logic [BYTE_W-1:0] fid_i,
  output logic [BYTE_W-1:0] pid_o,
  output logic              par_ok_o
);
  logic p0, p1;

  always_comb begin
    p0       = fid_i[0] ^ fid_i[1] ^ fid_i[2] ^ fid_i[4];
    p1       = ~(fid_i[1] ^ fid_i[3] ^ fid_i[4] ^ fid_i[5]);
    pid_o    = {p1, p0, fid_i[ID_W-1:0]};
    par_ok_o = (fid_i[7] == p1) && (fid_i[6] == p0);
  end
endmodule

// File: rtl/lin_len_unit.sv
module lin_len_unit #(
  parameter int LEN_W = 8,
  localparam int CNT_W = LEN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             from_id_i,
  input  logic [LEN_W-1:0] len_cfg_i,
  input  logic [1:0]       id_code_i,
  output logic [LEN_W:0]   exp_len_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (from_id_i) begin
      unique case (id_code_i)
        2'b10:   exp_len_o = (LEN_W+1)'(4);
        2'b11:   exp_len_o = (LEN_W+1)'(8);
        default: exp_len_o = (LEN_W+1)'(2);
      endcase
    end else begin
      exp_len_o = {1'b0, len_cfg_i} + (LEN_W+1)'(1);
    end
  end

  assign cnt_nxt_o = (inc_i && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_nxt_o;
  end

  a_r4_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_len_o != '0 && exp_len_o <= ((LEN_W+1)'(1) << LEN_W));
  a_r9_cnt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cnt_q) == CNT_MAX && !$past(clr_i) |-> cnt_q == CNT_MAX);
endmodule

// File: rtl/lin_sum_unit.sv
module lin_sum_unit
  import lin_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [BYTE_W-1:0] seed_i,
  input  logic              add_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] sum_nxt_o,
  output logic              rx_ok_o
);
  logic [BYTE_W-1:0] sum_q;

  assign sum_nxt_o = add_i ? add_eac(sum_q, byte_i) : sum_q;
  // received checksum closes the running sum to all ones
  assign rx_ok_o   = add_eac(sum_q, byte_i) == '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= seed_i;
    else            sum_q <= sum_nxt_o;
  end
endmodule

// File: rtl/lin_frame_guard.sv
module lin_frame_guard
  import lin_guard_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              master_i,
  input  logic              par_off_i,
  input  logic              sum_off_i,
  input  logic              sum_classic_i,
  input  logic              len_from_id_i,
  input  logic [LEN_W-1:0]  len_cfg_i,
  input  logic [BYTE_W-1:0] frame_id_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              byte_last_i,
  output logic [BYTE_W-1:0] pid_o,
  output logic [LEN_W:0]    exp_len_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] chk_o,
  output logic              par_err_o,
  output logic              sum_err_o,
  output logic              cnt_err_o
);
  localparam int CNT_W = LEN_W + 2;

  cfg_t              cfg_q;
  logic [LEN_W-1:0]  len_cfg_q;
  logic [BYTE_W-1:0] pid_q, pid_calc, pid_nxt, seed;
  logic              par_ok, open_q;
  logic              accept, fin, chk_byte, data_byte;
  logic [BYTE_W-1:0] sum_nxt;
  logic              rx_ok;
  logic [CNT_W-1:0]  cnt_nxt;

  lin_pid_unit u_pid (
    .fid_i    (frame_id_i),
    .pid_o    (pid_calc),
    .par_ok_o (par_ok)
  );

  assign pid_nxt = (master_i && !par_off_i) ? pid_calc : frame_id_i;
  assign seed    = sum_classic_i ? '0 : pid_nxt;

  // the start-of-frame cycle never accepts a byte
  assign accept    = byte_vld_i && open_q && !sof_i;
  assign fin       = accept && byte_last_i;
  assign chk_byte  = fin && !cfg_q.master && !cfg_q.sum_off;
  assign data_byte = accept && !chk_byte;

  lin_sum_unit u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sof_i),
    .seed_i    (seed),
    .add_i     (data_byte),
    .byte_i    (byte_i),
    .sum_nxt_o (sum_nxt),
    .rx_ok_o   (rx_ok)
  );

  lin_len_unit #(.LEN_W(LEN_W)) u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sof_i),
    .inc_i     (data_byte),
    .from_id_i (cfg_q.len_from_id),
    .len_cfg_i (len_cfg_q),
    .id_code_i (pid_q[5:4]),
    .exp_len_o (exp_len_o),
    .cnt_nxt_o (cnt_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      len_cfg_q <= '0;
      pid_q     <= '0;
      open_q    <= 1'b0;
      par_err_o <= 1'b0;
      sum_err_o <= 1'b0;
      cnt_err_o <= 1'b0;
      done_o    <= 1'b0;
      chk_o     <= '0;
    end else if (sof_i) begin
      cfg_q     <= '{master: master_i, par_off: par_off_i, sum_off: sum_off_i,
                     sum_classic: sum_classic_i, len_from_id: len_from_id_i};
      len_cfg_q <= len_cfg_i;
      pid_q     <= pid_nxt;
      open_q    <= 1'b1;
      par_err_o <= !master_i && !par_off_i && !par_ok;
      sum_err_o <= 1'b0;
      cnt_err_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        open_q    <= 1'b0;
        chk_o     <= (cfg_q.master && !cfg_q.sum_off) ? ~sum_nxt : '0;
        sum_err_o <= chk_byte && !rx_ok;
        cnt_err_o <= cnt_nxt != CNT_W'(exp_len_o);
      end
    end
  end

  assign pid_o = pid_q;

  a_r10_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(par_err_o) || $fell(sum_err_o) || $fell(cnt_err_o)) |-> $past(sof_i));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_master_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.master |-> !sum_err_o && !par_err_o);
  a_r2_par_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.par_off |-> !par_err_o);
  a_r8_sum_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.sum_off |-> !sum_err_o);
endmodule

// File: tb/lin_frame_guard_test.sv
module lin_frame_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 0, master = 0, par_off = 0, sum_off = 0, sum_classic = 0, len_from_id = 0;
  logic [LEN_W-1:0] len_cfg = '0;
  logic [7:0] frame_id = '0, byt = '0;
  logic vld = 0, last = 0;
  logic [7:0] pid, chk;
  logic [LEN_W:0] exp_len;
  logic done, par_err, sum_err, cnt_err;
  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] dbuf [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_frame_guard #(.LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .master_i(master), .par_off_i(par_off),
    .sum_off_i(sum_off), .sum_classic_i(sum_classic), .len_from_id_i(len_from_id),
    .len_cfg_i(len_cfg), .frame_id_i(frame_id), .byte_i(byt), .byte_vld_i(vld),
    .byte_last_i(last), .pid_o(pid), .exp_len_o(exp_len), .done_o(done), .chk_o(chk),
    .par_err_o(par_err), .sum_err_o(sum_err), .cnt_err_o(cnt_err));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] f_eac(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 255) s = s - 255;
    return s[7:0];
  endfunction

  function automatic logic [7:0] f_pid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic int f_len(input bit lid, input logic [7:0] lc, input logic [1:0] code);
    if (!lid) return int'(lc) + 1;
    case (code)
      2'b10: return 4;
      2'b11: return 8;
      default: return 2;
    endcase
  endfunction

  task automatic do_frame(input bit m, input bit pof, input bit soff, input bit cls,
                          input bit lid, input logic [7:0] lc, input logic [7:0] fid,
                          input int nd, input bit bad, input bit gaps);
    logic [7:0] pe, sum, rx, ref_pid, exp_chk;
    int elen, total;
    bit exp_par, exp_serr, exp_cerr;
    ref_pid  = f_pid(fid[5:0]);
    pe       = (m && !pof) ? ref_pid : fid;
    elen     = f_len(lid, lc, fid[5:4]);
    exp_par  = !m && !pof && (fid[7:6] != ref_pid[7:6]);
    sum      = cls ? 8'h00 : pe;
    for (int i = 0; i < nd; i++) begin
      dbuf[i] = 8'($urandom);
      sum = f_eac(sum, dbuf[i]);
    end
    rx       = ~sum ^ (bad ? 8'h01 : 8'h00);
    exp_serr = !m && !soff && (f_eac(sum, rx) != 8'hFF);
    exp_chk  = (m && !soff) ? ~sum : 8'h00;
    exp_cerr = (nd != elen);
    total    = nd + ((!m && !soff) ? 1 : 0);

    @(negedge clk);
    sof = 1; master = m; par_off = pof; sum_off = soff; sum_classic = cls;
    len_from_id = lid; len_cfg = lc; frame_id = fid;
    vld = 1; last = 1; byt = 8'hA5; // must be ignored in the start-of-frame cycle
    @(negedge clk);
    sof = 0; vld = 0; last = 0;
    master = !m; frame_id = ~fid; // later changes must not matter
    check(pid == pe, "R1/R2", "pid_o", pid, pe);
    check(int'(exp_len) == elen, lid ? "R5" : "R4", "exp_len_o", exp_len, elen);
    check(par_err == exp_par, "R3", "par_err_o", par_err, exp_par);
    check(!sum_err && !cnt_err && !done, "R10", "cleared at sof", {sum_err, cnt_err, done}, 0);
    for (int i = 0; i < total; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        vld = 0; last = 0;
        @(negedge clk);
      end
      byt = (i < nd) ? dbuf[i] : rx;
      vld = 1; last = (i == total - 1);
      @(negedge clk);
    end
    vld = 0; last = 0;
    check(done == 1'b1, "R11", "done_o", done, 1);
    check(chk == exp_chk, soff ? "R8" : "R6", "chk_o", chk, exp_chk);
    check(sum_err == exp_serr, soff ? "R8" : "R7", "sum_err_o", sum_err, exp_serr);
    check(cnt_err == exp_cerr, "R9", "cnt_err_o", cnt_err, exp_cerr);
    @(negedge clk);
    check(done == 1'b0, "R11", "done_o pulse width", done, 0);
    check(par_err == exp_par && sum_err == exp_serr && cnt_err == exp_cerr, "R10",
          "flags held", {par_err, sum_err, cnt_err}, {exp_par, exp_serr, exp_cerr});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] chk_keep;
    void'($urandom(32'd731));
    repeat (3) @(negedge clk);
    check(pid == 8'h00 && chk == 8'h00 && !done && !par_err && !sum_err && !cnt_err,
          "R10", "reset state", {pid, chk}, 0);
    check(int'(exp_len) == 1, "R4", "reset exp_len_o", exp_len, 1);
    rst_n = 1;
    @(negedge clk);

    // R1 literal parity values
    do_frame(1, 0, 0, 0, 1, 8'd0, 8'h00, 2, 0, 0);
    check(pid == 8'h80, "R1", "pid for id 00", pid, 8'h80);
    do_frame(1, 0, 0, 1, 1, 8'd0, 8'h3F, 8, 0, 0);
    check(pid == 8'hBF, "R1", "pid for id 3F", pid, 8'hBF);
    // R2 parity off keeps the byte as given
    do_frame(1, 1, 0, 0, 0, 8'd3, 8'hC5, 4, 0, 0);
    do_frame(0, 1, 0, 1, 0, 8'd1, 8'h7A, 2, 0, 0);
    // R3 slave parity errors and a clean one
    do_frame(0, 0, 0, 0, 1, 8'd0, {~f_pid(6'h11)} & 8'hC0 | 8'h11, 2, 0, 0);
    do_frame(0, 0, 0, 0, 1, 8'd0, f_pid(6'h2C), 4, 0, 0);
    // R5 every identifier length code
    for (int c = 0; c < 4; c++) do_frame(0, 0, 0, 0, 1, 8'd9, f_pid(6'(c << 4) | 6'h3), (c == 3) ? 8 : ((c == 2) ? 4 : 2), 0, 1);
    // R4/R6 full 256-byte response, both coverages
    do_frame(1, 0, 0, 0, 0, 8'd255, 8'h15, 256, 0, 0);
    do_frame(0, 0, 0, 1, 0, 8'd255, f_pid(6'h15), 256, 1, 0);
    // R7 bad checksum, R8 checksum off
    do_frame(0, 0, 0, 0, 0, 8'd5, f_pid(6'h09), 6, 1, 1);
    do_frame(0, 0, 1, 0, 0, 8'd5, f_pid(6'h09), 6, 1, 0);
    do_frame(1, 0, 1, 0, 0, 8'd2, 8'h21, 3, 0, 0);
    // R9 short and long responses
    do_frame(1, 0, 0, 1, 0, 8'd4, 8'h01, 4, 0, 0);
    do_frame(0, 0, 0, 0, 1, 8'd0, f_pid(6'h30), 9, 0, 0);

    // R11 bytes outside a frame are ignored
    chk_keep = chk;
    vld = 1; last = 1; byt = 8'h5A;
    @(negedge clk);
    vld = 0; last = 0;
    check(done == 1'b0, "R11", "done_o after stray byte", done, 0);
    check(chk == chk_keep, "R11", "chk_o after stray byte", chk, chk_keep);

    // constrained random frames
    for (int k = 0; k < 60; k++) begin
      bit m, pof, soff, cls, lid, bad;
      logic [7:0] lc, fid;
      int e, nd;
      m = 1'($urandom); pof = ($urandom % 5 == 0); soff = ($urandom % 5 == 0);
      cls = 1'($urandom); lid = 1'($urandom); bad = ($urandom % 4 == 0);
      lc = 8'($urandom % 24);
      fid = 8'($urandom);
      if (!m && ($urandom % 3 != 0)) fid = f_pid(fid[5:0]);
      e = f_len(lid, lc, fid[5:4]);
      nd = e;
      if ($urandom % 5 == 0) nd = e + 1;
      else if ($urandom % 5 == 0 && e > 1) nd = e - 1;
      do_frame(m, pof, soff, cls, lid, lc, fid, nd, bad, 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule